// File: doc/BRIEF.md
# Bus Error Capture Register

This block is a 64-bit control and status word that records error events seen on a bus interface. Every error source has two bits in the word: an enable bit and a sticky flag bit. Each source reports a one-cycle pulse when its error happens. That pulse sets the source's flag only while the source's enable is 1.

Software reaches the word through a simple port. A write strobe carries a full 64-bit value. The current contents are always visible on a read bus. Enables are plain read/write bits. A flag is cleared by writing 1 to it. Writing 0 to a flag leaves it as it is.

A single error line combines the sources. It is high when at least one source has both its flag and its enable set, and it is registered, so it lags the register state by one clock.

Top module: `bus_err_flag_reg`

## Requirements
- R1: After synchronous reset all 64 bits of `rd_data` read 0 and `err_out` is 0.
- R2: Enable bits sit at bit positions 0 (master abort received), 1 (target abort received), 3 (exception), 4 (system error), 5 (parity error) and 6 (target abort signaled). Each flag sits 16 bits above its enable, at bits 16, 17, 19, 20, 21 and 22. Pulse input `evt_in[i]` is the event for the enable at bit i.
- R3: A pulse on `evt_in[i]` while enable i is 1 makes flag i read 1 from the next clock onward.
- R4: A pulse on `evt_in[i]` while enable i is 0 leaves flag i unchanged.
- R5: A write with bit 16+i set clears flag i at the next clock.
- R6: A write with bit 16+i at 0 leaves flag i unchanged.
- R7: Bits 2, 18, 7–15 and 23–63 always read 0 and ignore writes. `evt_in[2]` has no effect.
- R8: If an enabled event for flag i and a write-1-to-clear of flag i arrive in the same cycle, the flag remains 1.
- R9: Enable bits take the written value on every write. Clearing an enable does not clear a flag that is already set.
- R10: `err_out` equals the OR over all sources of (flag AND enable), as those bits stood one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 64 | Register write value |
| rd_data | output | 64 | Current register contents |
| evt_in | input | 7 | Per-source error pulses, indexed by enable bit position |
| err_out | output | 1 | Registered combined error line |

## Verification
The bench builds the block with its default parameters: a 64-bit word, seven enable slots with slot 2 reserved, and flags offset by 16. With these values every implemented source and the reserved slot can be reached directly. Random mixes of writes and event pulses are therefore able to hit each bit position. That includes the cycles where an event and a clear collide and the cycles where an enable is dropped under a set flag.

// File: rtl/bef_pkg.sv
package bef_pkg;
  localparam int unsigned BEF_DATA_W   = 64;
  localparam int unsigned BEF_SLOTS    = 7;
  localparam int unsigned BEF_FLAG_OFS = 16;
  // slot 2 is reserved; 1 = implemented
  localparam logic [BEF_SLOTS-1:0] BEF_SLOT_MASK = 7'b111_1011;

  typedef enum logic [2:0] {
    SRC_MABORT_RX = 3'd0,
    SRC_TABORT_RX = 3'd1,
    SRC_RESERVED  = 3'd2,
    SRC_EXCEPTION = 3'd3,
    SRC_SYSERR    = 3'd4,
    SRC_PARITY    = 3'd5,
    SRC_TABORT_TX = 3'd6
  } bef_src_e;
endpackage

// File: rtl/bef_slot.sv
module bef_slot (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_en_bit,
  input  logic wr_clr_bit,
  input  logic evt,
  output logic en_q,
  output logic flag_q
);
  logic set_now;
  logic clr_now;

  assign set_now = evt & en_q;
  assign clr_now = wr_en & wr_clr_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (wr_en) en_q <= wr_en_bit;
      if (set_now)      flag_q <= 1'b1;
      else if (clr_now) flag_q <= 1'b0;
    end
  end

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    (evt && en_q) |=> flag_q); // R3
  AST_FLAG_NO_SET: assert property (@(posedge clk) disable iff (rst)
    (!flag_q && !(evt && en_q)) |=> !flag_q); // R4
  AST_W1C: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_clr_bit && !(evt && en_q)) |=> !flag_q); // R5
  AST_W0_KEEP: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !(wr_en && wr_clr_bit)) |=> flag_q); // R6
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (evt && en_q && wr_en && wr_clr_bit) |=> flag_q); // R8
  AST_EN_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (en_q == $past(wr_en_bit))); // R9
endmodule

// File: rtl/bef_err_combine.sv
module bef_err_combine #(
  parameter int unsigned SLOTS = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SLOTS-1:0] en_vec,
  input  logic [SLOTS-1:0] flag_vec,
  output logic             err_q
);
  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= |(en_vec & flag_vec);
  end

  AST_ERR_LATENCY: assert property (@(posedge clk) disable iff (rst)
    ##1 (err_q == $past(|(en_vec & flag_vec)))); // R10
endmodule

// File: rtl/bus_err_flag_reg.sv
module bus_err_flag_reg
  import bef_pkg::*;
#(
  parameter int unsigned DATA_W   = BEF_DATA_W,
  parameter int unsigned SLOTS    = BEF_SLOTS,
  parameter int unsigned FLAG_OFS = BEF_FLAG_OFS,
  parameter logic [SLOTS-1:0] SLOT_MASK = BEF_SLOT_MASK
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic [SLOTS-1:0]  evt_in,
  output logic              err_out
);
  localparam int unsigned FLAG_TOP = FLAG_OFS + SLOTS - 1;
  localparam logic [DATA_W-1:0] LIVE_MASK =
    (DATA_W'(SLOT_MASK)) | (DATA_W'(SLOT_MASK) << FLAG_OFS);

  logic [SLOTS-1:0] en_vec;
  logic [SLOTS-1:0] flag_vec;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    if (SLOT_MASK[i]) begin : g_live
      bef_slot u_slot (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_en_bit  (wr_data[i]),
        .wr_clr_bit (wr_data[FLAG_OFS+i]),
        .evt        (evt_in[i]),
        .en_q       (en_vec[i]),
        .flag_q     (flag_vec[i])
      );
    end else begin : g_rsvd
      assign en_vec[i]   = 1'b0;
      assign flag_vec[i] = 1'b0;
    end
  end

  logic unused_bits;
  assign unused_bits = ^(wr_data & ~LIVE_MASK) ^ ^(evt_in & ~SLOT_MASK);

  always_comb begin
    rd_data = '0;
    rd_data[SLOTS-1:0]        = en_vec;
    rd_data[FLAG_TOP:FLAG_OFS] = flag_vec;
  end

  bef_err_combine #(.SLOTS(SLOTS)) u_err (
    .clk      (clk),
    .rst      (rst),
    .en_vec   (en_vec),
    .flag_vec (flag_vec),
    .err_q    (err_out)
  );

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    ((rd_data & ~LIVE_MASK) == '0)); // R7
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (rd_data == '0 && !err_out)); // R1
endmodule

// File: tb/sim_bus_err_flag_reg.sv
module sim_bus_err_flag_reg;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [63:0] wr_data;
  logic [63:0] rd_data;
  logic [6:0]  evt_in;
  logic        err_out;

  int n_chk = 0;
  int n_err = 0;
  logic [6:0] m_en, m_fl;
  logic       m_err;
  localparam logic [6:0] LIVE = 7'b111_1011;

  always #5 clk = ~clk;

  bus_err_flag_reg u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .evt_in(evt_in), .err_out(err_out)
  );

  function automatic logic [63:0] exp_rd(input logic [6:0] en, input logic [6:0] fl);
    logic [63:0] r;
    r = '0;
    r[6:0]   = en & LIVE;
    r[22:16] = fl & LIVE;
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, model update at edge, compare at next negedge
  task automatic step(input logic we, input logic [63:0] wd, input logic [6:0] ev, input string req);
    logic [6:0] set_v, clr_v, en_n;
    wr_en = we; wr_data = wd; evt_in = ev;
    @(posedge clk);
    set_v = ev & m_en & LIVE;
    clr_v = we ? (wd[22:16] & LIVE) : 7'b0;
    en_n  = we ? (wd[6:0] & LIVE) : m_en;
    m_err = |(m_en & m_fl);
    m_fl  = set_v | (m_fl & ~clr_v);
    m_en  = en_n;
    @(negedge clk);
    check(req, rd_data, exp_rd(m_en, m_fl));
    check({req, " R10 err"}, {63'b0, err_out}, {63'b0, m_err});
  endtask

  initial begin
    #2_000_000;
    n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd4242);
    rst = 1'b1; wr_en = 0; wr_data = '0; evt_in = '0;
    m_en = '0; m_fl = '0; m_err = 0;
    repeat (3) @(posedge clk);
    // drive events during reset: must not matter
    evt_in = 7'h7f; wr_en = 1; wr_data = '1;
    @(posedge clk); @(negedge clk);
    check("R1 reset", rd_data, 64'h0);
    check("R1 err reset", {63'b0, err_out}, 64'h0);
    rst = 1'b0;
    // R4: events with enables off
    step(0, 64'h0, 7'h7f, "R4 no enable");
    // R7: write all ones, reserved bits stay 0, evt_in[2] ignored
    step(1, 64'hffff_ffff_ffff_ffff & ~64'h007f_0000, 7'h04, "R7 reserved");
    check("R2 R7 layout", rd_data, 64'h0000_0000_0000_007b);
    // R3 per-source position, R2
    for (int i = 0; i < 7; i++) begin
      step(0, 64'h0, 7'(1 << i), "R3 R2 set");
    end
    check("R2 flags", rd_data, 64'h0000_0000_007b_007b);
    // R9: clearing enables keeps flags, masks error
    step(1, 64'h0, 7'h0, "R9 enable clear");
    step(0, 64'h0, 7'h0, "R9 R10 masked");
    check("R10 masked err", {63'b0, err_out}, 64'h0);
    // R6: write 0 to flags leaves them
    step(1, 64'h0000_0000_0000_0003, 7'h0, "R6 w0");
    // R5: clear flag 20 only
    step(1, 64'h0000_0000_0010_0003, 7'h0, "R5 w1c");
    check("R5 value", rd_data, 64'h0000_0000_006b_0003);
    // R8: event + clear on slot 0 in the same cycle
    step(1, 64'h0000_0000_0001_0003, 7'h01, "R8 set wins");
    check("R8 value", rd_data[16], 1'b1);
    // random mix
    for (int k = 0; k < 3000; k++) begin
      logic [63:0] wd;
      logic we;
      wd = {$urandom, $urandom};
      we = ($urandom % 4) == 0;
      step(we, wd, 7'($urandom % 128) & 7'($urandom % 128), "R3 R5 R10 random");
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule